// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block walks a synchronous DRAM burst through its column addresses. A read or write command, shown to the block as a one-cycle `start` pulse, brings in the first column together with two mode fields. The first field is a length code that selects 1, 2, 4 or 8 beats. The second field is an ordering bit that selects either a wrapping increment or an XOR-scrambled walk. From the next cycle on, the block presents one column per clock on `col_out` and marks it with `col_valid`. It raises `col_last` on the final beat. The row stays open and only the column changes.

A burst can be cut short in two ways. A precharge, shown as `stop`, ends it at once. A fresh command, shown as another `start`, abandons the old sequence and loads the new one. The output stream has no ready input. A DRAM column must advance on every clock, so the block can accept no back-pressure, and the consumer must take one column per cycle while `col_valid` is high.

Top module: `burst_colgen`

## Requirements
- R1: After reset, `col_valid` and `col_last` are both low.
- R2: A `start` sampled at a clock edge makes `col_valid` high from the next cycle, with `col_out` equal to the sampled `start_col` (beat 0).
- R3: `len_code` values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `col_valid` stays high for exactly that many consecutive cycles.
- R4: With `order_xor` = 0, beat k presents the aligned block base plus ((start offset + k) mod L). Here L is the burst length and the offset is `start_col` mod L.
- R5: With `order_xor` = 1, beat k presents `start_col` with its low log2(L) bits XORed with k.
- R6: Within a burst, column bits 3 and above never change from beat to beat.
- R7: For L of 2 or more, the least significant column bit alternates between every pair of consecutive beats.
- R8: With L = 1, exactly one column equal to `start_col` is presented, whatever the value of `order_xor`.
- R9: `col_last` is high only together with the final column of the burst. In the cycle after it, `col_valid` is low unless `start` was sampled on that beat.
- R10: `stop` sampled without `start` during a burst makes `col_valid` low from the next cycle.
- R11: A `start` sampled during an active burst reloads the sequence from the new `start_col` in the next cycle. When `start` and `stop` are sampled together, `start` wins.
- R12: `len_code` and `order_xor` are sampled only with `start`. Changing them mid-burst does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Read/write command strobe, loads a new burst |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 2 | Burst length code: 0→1, 1→2, 2→4, 3→8 beats |
| order_xor | input | 1 | 0 = wrapping increment, 1 = XOR-scrambled order |
| stop | input | 1 | Precharge strobe, ends the current burst |
| col_out | output | COL_W | Current column address |
| col_valid | output | 1 | `col_out` holds a burst beat |
| col_last | output | 1 | Final beat of the burst |

## Verification
On every cycle, the assertions check the beat-to-beat invariants. These cover the loading of `start_col` one cycle after `start`, the stable upper column bits, the toggling low bit, `col_last` never appearing without `col_valid`, and the drop of `col_valid` after a last beat or after a `stop`. The exact order of the low bits for each length and ordering can only be shown by the bench. So can the exact burst length, the behaviour of length 1 under either ordering bit, the reload on a mid-burst command, and the fact that mode changes after `start` are ignored. The bench sweeps every length code, both orderings and every start offset in two column blocks, and compares each column against arithmetic.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int BEAT_W = 3;

  typedef enum logic {
    ORD_WRAP = 1'b0,
    ORD_XOR  = 1'b1
  } order_e;

  // Mask over the low column bits that a burst of the given length may touch.
  function automatic logic [BEAT_W-1:0] beat_mask(input logic [1:0] code);
    logic [3:0] span;
    span = (4'd1 << code) - 4'd1;
    return span[BEAT_W-1:0];
  endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [COL_W-1:0]  start_col,
  input  logic [1:0]        code_in,
  input  logic              order_in,
  output logic [COL_W-1:0]  base_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic [1:0]        code_q,
  output order_e            order_q,
  output logic              active_q,
  output logic              last
);

  logic [BEAT_W-1:0] mask;

  assign mask = beat_mask(code_q);
  assign last = active_q && (beat_q == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      code_q   <= 2'd0;
      order_q  <= ORD_WRAP;
    end else if (start) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= start_col;
      code_q   <= code_in;
      order_q  <= order_e'(order_in);
    end else if (stop) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (last) active_q <= 1'b0;
      else      beat_q   <= beat_q + 1'b1;
    end
  end

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> !active_q); // R10

  AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !active_q); // R9

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0]  base,
  input  logic [BEAT_W-1:0] beat,
  input  logic [1:0]        code,
  input  order_e            order,
  output logic [COL_W-1:0]  col
);

  localparam int HI_W = COL_W - BEAT_W;

  logic [BEAT_W-1:0] mask;
  logic [BEAT_W-1:0] lo;
  logic [BEAT_W-1:0] wrap_lo;
  logic [BEAT_W-1:0] xor_lo;
  logic [BEAT_W-1:0] sum;

  assign mask    = beat_mask(code);
  assign lo      = base[BEAT_W-1:0];
  assign sum     = lo + beat;
  assign wrap_lo = (lo & ~mask) | (sum & mask);
  assign xor_lo  = lo ^ (beat & mask);

  generate
    if (HI_W > 0) begin : g_hi
      assign col = {base[COL_W-1:BEAT_W], (order == ORD_XOR) ? xor_lo : wrap_lo};
    end else begin : g_lo_only
      assign col = (order == ORD_XOR) ? xor_lo : wrap_lo;
    end
  endgenerate

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       len_code,
  input  logic             order_xor,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last
);

  logic [COL_W-1:0]  base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [1:0]        code_q;
  order_e            order_q;
  logic              active_q;
  logic              last;

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .start_col (start_col),
    .code_in   (len_code),
    .order_in  (order_xor),
    .base_q    (base_q),
    .beat_q    (beat_q),
    .code_q    (code_q),
    .order_q   (order_q),
    .active_q  (active_q),
    .last      (last)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base  (base_q),
    .beat  (beat_q),
    .code  (code_q),
    .order (order_q),
    .col   (col_out)
  );

  assign col_valid = active_q;
  assign col_last  = last;

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid); // R9

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_out == $past(start_col))); // R2

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !start && !stop) |=>
      (col_out[COL_W-1:BEAT_W] == $past(col_out[COL_W-1:BEAT_W]))); // R6

  AST_LSB_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !start && !stop) |=>
      (col_valid && col_out[0] != $past(col_out[0]))); // R7

endmodule

// File: tb/sim_burst_colgen.sv
`timescale 1ns/1ps
module sim_burst_colgen;

  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [1:0]       len_code = 2'd0;
  logic             order_xor = 1'b0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             col_last;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_colgen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .order_xor(order_xor), .stop(stop),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(input int c, input int code, input int xo, input int k);
    int len, base, off;
    len  = 1 << code;
    off  = c % len;
    base = c - off;
    if (xo != 0) return base + (off ^ k);
    return base + ((off + k) % len);
  endfunction

  // One full burst; mode inputs are scrambled after start (R12).
  task automatic run_burst(input int c, input int code, input int xo);
    int len;
    len = 1 << code;
    @(posedge clk); #1;
    start = 1'b1; start_col = COL_W'(c); len_code = 2'(code); order_xor = xo[0];
    @(posedge clk); #1;
    start = 1'b0; len_code = ~len_code; order_xor = ~order_xor; start_col = ~start_col;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk(col_valid == 1'b1, "R3 valid during burst", int'(col_valid), 1);
      if (xo != 0) chk(int'(col_out) == exp_col(c, code, xo, k), "R5 xor order",
                       int'(col_out), exp_col(c, code, xo, k));
      else chk(int'(col_out) == exp_col(c, code, xo, k), "R4 wrap order",
               int'(col_out), exp_col(c, code, xo, k));
      chk(col_last == (k == len - 1), "R9 last flag", int'(col_last), int'(k == len - 1));
      if (code == 0) chk(int'(col_out) == c, "R8 single beat", int'(col_out), c);
      if (k < len - 1) @(posedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    chk(col_valid == 1'b0, "R3 burst ends after L beats", int'(col_valid), 0);
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk(col_valid == 1'b0, "R1 valid at reset", int'(col_valid), 0);
    chk(col_last == 1'b0, "R1 last at reset", int'(col_last), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(col_valid == 1'b0, "R1 idle after reset", int'(col_valid), 0);

    // Sweep: every length, both orders, all offsets in two blocks (R2..R8, R12)
    for (int code = 0; code < 4; code++)
      for (int xo = 0; xo < 2; xo++)
        for (int c = 0; c < 8; c++) begin
          run_burst(8'h30 + c, code, xo);
          run_burst(8'hc8 + c, code, xo);
        end

    // R10: stop mid-burst
    @(posedge clk); #1;
    start = 1'b1; start_col = 8'h15; len_code = 2'd3; order_xor = 1'b0;
    @(posedge clk); #1 start = 1'b0;
    @(posedge clk);
    @(posedge clk); #1 stop = 1'b1;
    @(negedge clk);
    chk(col_valid == 1'b1, "R10 still valid before stop edge", int'(col_valid), 1);
    chk(int'(col_out) == 8'h17, "R10 beat before stop", int'(col_out), 8'h17);
    @(posedge clk); #1 stop = 1'b0;
    @(negedge clk);
    chk(col_valid == 1'b0, "R10 stop ends burst", int'(col_valid), 0);

    // R11: start with stop during burst reloads
    @(posedge clk); #1;
    start = 1'b1; start_col = 8'h0b; len_code = 2'd3; order_xor = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(posedge clk); #1;
    start = 1'b1; stop = 1'b1; start_col = 8'h46; len_code = 2'd2; order_xor = 1'b0;
    @(posedge clk); #1 start = 1'b0; stop = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(col_valid && int'(col_out) == exp_col(8'h46, 2, 0, k), "R11 reload sequence",
          int'(col_out), exp_col(8'h46, 2, 0, k));
      if (k < 3) @(posedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    chk(col_valid == 1'b0, "R11 reloaded burst length", int'(col_valid), 0);

    // R9: start on last beat keeps valid continuous
    @(posedge clk); #1;
    start = 1'b1; start_col = 8'h21; len_code = 2'd1; order_xor = 1'b0;
    @(posedge clk); #1 start = 1'b0;
    @(posedge clk); #1;
    start = 1'b1; start_col = 8'h7a; len_code = 2'd0;
    @(negedge clk);
    chk(col_last == 1'b1 && int'(col_out) == 8'h20, "R9 last of first burst", int'(col_out), 8'h20);
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(col_valid == 1'b1 && int'(col_out) == 8'h7a, "R9 back-to-back start", int'(col_out), 8'h7a);
    @(posedge clk);
    @(negedge clk);
    chk(col_valid == 1'b0, "R9 drop after single beat", int'(col_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule